// File: doc/BRIEF.md
# Byte-Framed SPI Slave Shifter

This block is the receive/transmit engine of an SPI slave port. It shifts one byte at a time, most significant bit first, in from the MOSI line and out on the MISO line. It handles both clock idle levels and both clock phases. The serial clock, the active-low select and MOSI are brought into the system clock domain through two-flop synchronisers. All edges are detected there, so the system clock must run at least four times faster than the serial clock.

In phase-zero operation every byte has its own select assertion. The falling edge of select loads the transmit byte and places its top bit on MISO before the master produces any clock edge. Select must go high again before the next byte. A ninth sampling edge inside one select-low window is reported as a framing error. In phase-one operation the master may clock several bytes back to back under one select. The next transmit byte is reloaded each time a byte completes.

The MISO output-enable is asserted only while the block is enabled and select is low, so other slaves can share the line. The polarity and phase settings are written through a configuration strobe, which takes effect only while the block is disabled.

Top module: `spi_byte_slave`

## Requirements
- R1: `miso_oe_o` is 1 only while `en_i` is 1 and the synchronised select is low; otherwise it is 0 and `miso_o` is 0.
- R2: With polarity 0 the leading edge of a bit is the rising serial clock edge; with polarity 1 it is the falling edge (the clock idles at the polarity level).
- R3: With phase 0, the MSB of `tx_data_i` appears on `miso_o` within 4 system cycles of select falling, before any serial clock edge.
- R4: With phase 0, MOSI is sampled on leading edges and the next MISO bit is shifted out on trailing edges, MSB first, 8 bits per byte.
- R5: With phase 1, MISO changes on leading edges and MOSI is sampled on trailing edges; consecutive bytes under one select are received, and `tx_data_i` is reloaded when each byte completes.
- R6: After the 8th sampling edge of a byte, `rx_data_o` holds the received byte and `rx_full_o` pulses high for exactly one system cycle.
- R7: With phase 0, a 9th sampling edge in one select-low window sets `frame_err_o` and produces no `rx_full_o`; the flag holds until the next select fall, which clears it.
- R8: If select rises before 8 sampling edges, the partial byte is discarded and no `rx_full_o` pulse occurs.
- R9: `cfg_we_i` loads `cpol_i`/`cpha_i` only while `en_i` is 0; writes while enabled leave the mode unchanged.
- R10: After reset `rx_full_o`, `frame_err_o`, `miso_oe_o` and `miso_o` are 0; polarity and phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| cfg_we_i | input | 1 | Mode write strobe |
| cpol_i | input | 1 | Clock polarity value to write |
| cpha_i | input | 1 | Clock phase value to write |
| sclk_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| ss_ni | input | 1 | Active-low slave select |
| tx_data_i | input | 8 | Byte to transmit |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | MISO output-enable |
| rx_data_o | output | 8 | Last received byte |
| rx_full_o | output | 1 | One-cycle byte-received pulse |
| frame_err_o | output | 1 | Phase-zero overrun framing error |

## Verification
The hardest situations to reach are those where the master misbehaves inside one select window. These are a ninth clock edge in phase 0, and a select that rises partway through a byte. The driver task counts the edges it issues itself. It can stop after a chosen number of bits and release select, or issue one extra edge after a full byte. The scoreboard queue holds only bytes that should complete, so any stray receive pulse from a discarded or overrun byte shows up as an unexpected pop. A mode write made while enabled is followed by a transfer in the old mode. That transfer would corrupt data if the write had taken effect.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= RST_VAL;
    else prev_o <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
  import spi_slv_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  spi_mode_t     mode_i,
  input  logic          sel_i,
  input  logic          sel_fall_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          mosi_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          miso_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          frame_err_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_sh_q, tx_sh_q;
  logic          sample, shift;

  assign sample = mode_i.cpha ? trail_i : lead_i;
  assign shift  = mode_i.cpha ? lead_i  : trail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      rx_data_o   <= '0;
      rx_full_o   <= 1'b0;
      frame_err_o <= 1'b0;
      miso_o      <= 1'b0;
    end else begin
      rx_full_o <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (sel_fall_i) begin
        cnt_q       <= '0;
        frame_err_o <= 1'b0;
        if (!mode_i.cpha) begin
          miso_o  <= tx_data_i[DW-1];
          tx_sh_q <= tx_data_i << 1;
        end else begin
          tx_sh_q <= tx_data_i;
        end
      end else begin
        if (shift) begin
          miso_o  <= tx_sh_q[DW-1];
          tx_sh_q <= tx_sh_q << 1;
        end
        if (sample) begin
          if (cnt_q == CNT_FULL) begin
            frame_err_o <= 1'b1;   // overrun in phase 0
          end else begin
            rx_sh_q <= {rx_sh_q[DW-2:0], mosi_i};
            if (cnt_q == CNT_LAST) begin
              rx_data_o <= {rx_sh_q[DW-2:0], mosi_i};
              rx_full_o <= 1'b1;
              if (mode_i.cpha) begin
                cnt_q   <= '0;
                tx_sh_q <= tx_data_i;
              end else begin
                cnt_q <= CNT_FULL;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |=> !rx_full_o);                                    // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);                                           // R7
  AST_ERR_PHASE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> !mode_i.cpha);                         // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (cnt_q == '0) && !rx_full_o);                      // R8
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cfg_we_i,
  input  logic       cpol_i,
  input  logic       cpha_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       ss_ni,
  input  logic [7:0] tx_data_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  output logic [7:0] rx_data_o,
  output logic       rx_full_o,
  output logic       frame_err_o
);
  localparam int unsigned DW = 8;

  spi_mode_t  mode_q;
  logic [2:0] pin_sync, pin_prev;
  logic       sclk_rise, sclk_fall, lead, trail;
  logic       act, act_q, sel_fall, miso_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (cfg_we_i && !en_i) mode_q <= '{cpol: cpol_i, cpha: cpha_i};
  end

  spi_slv_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ss_ni, sclk_i, mosi_i}),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  assign sclk_rise = pin_sync[1] & ~pin_prev[1];
  assign sclk_fall = ~pin_sync[1] & pin_prev[1];
  assign lead      = mode_q.cpol ? sclk_fall : sclk_rise;
  assign trail     = mode_q.cpol ? sclk_rise : sclk_fall;
  assign act       = en_i & ~pin_sync[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else act_q <= act;
  end
  assign sel_fall = act & ~act_q;

  spi_slv_core #(.DW(DW)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .sel_i      (act),
    .sel_fall_i (sel_fall),
    .lead_i     (lead),
    .trail_i    (trail),
    .mosi_i     (pin_sync[0]),
    .tx_data_i  (tx_data_i),
    .miso_o     (miso_bit),
    .rx_data_o  (rx_data_o),
    .rx_full_o  (rx_full_o),
    .frame_err_o(frame_err_o)
  );

  assign miso_oe_o = act;
  assign miso_o    = act & miso_bit;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(mode_q));                   // R9
  AST_OE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && $past(ss_ni) && $past(ss_ni, 2)) |-> !miso_oe_o);   // R1
endmodule

// File: tb/test_spi_byte_slave.sv
module test_spi_byte_slave;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       en_i = 1'b0, cfg_we_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  logic [7:0] tx_data_i = '0;
  logic       miso_o, miso_oe_o, rx_full_o, frame_err_o;
  logic [7:0] rx_data_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic cur_pol = 1'b0, cur_pha = 1'b0;
  localparam int HALF = 30;

  always #2.5 clk_i = ~clk_i;

  spi_byte_slave i_spi_byte_slave (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rx_full_o) begin
      if (exp_q.size() == 0) chk("R8 unexpected rx_full", {24'd0, rx_data_o}, 32'hFFFF_FFFF);
      else chk("R6 rx byte", {24'd0, rx_data_o}, {24'd0, exp_q.pop_front()});
    end
  end

  initial begin
    #2_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    en_i = 1'b0; cyc(1);
    cpol_i = pol; cpha_i = pha; cfg_we_i = 1'b1; cyc(1);
    cfg_we_i = 1'b0;
    sclk_i = pol; cur_pol = pol; cur_pha = pha;
    cyc(4);
    en_i = 1'b1; cyc(2);
  endtask

  task automatic sel(input logic lvl);
    ss_ni = lvl; #(HALF);
  endtask

  // drive nbits; returns bits read from MISO; next_tx loaded during last bit
  task automatic run_bits(input logic [7:0] m, input int nbits, input logic [7:0] next_tx,
                          output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cur_pha) begin
        mosi_i = m[7-i]; #(HALF);
        got = {got[6:0], miso_o};
        sclk_i = ~cur_pol; #(HALF);
        sclk_i = cur_pol;
      end else begin
        sclk_i = ~cur_pol; mosi_i = m[7-i];
        if (i == 7) tx_data_i = next_tx;
        #(HALF);
        got = {got[6:0], miso_o};
        sclk_i = cur_pol; #(HALF);
      end
    end
    #(HALF);
  endtask

  task automatic xfer(input string req, input logic [7:0] m, input logic [7:0] s);
    logic [7:0] got;
    tx_data_i = s;
    exp_q.push_back(m);
    sel(1'b0);
    run_bits(m, 8, s, got);
    sel(1'b1);
    chk(req, {24'd0, got}, {24'd0, s});
  endtask

  initial begin
    logic [7:0] got;
    cyc(3);
    chk("R10 rx_full", {31'd0, rx_full_o}, 0);
    chk("R10 frame_err", {31'd0, frame_err_o}, 0);
    chk("R10 oe", {31'd0, miso_oe_o}, 0);
    rst_ni = 1'b1; cyc(3);
    chk("R10 miso", {31'd0, miso_o}, 0);

    // R1: select low but disabled
    ss_ni = 1'b0; cyc(5);
    chk("R1 oe disabled", {31'd0, miso_oe_o}, 0);
    ss_ni = 1'b1; cyc(5);

    // R3/R4 phase 0 polarity 0
    set_mode(1'b0, 1'b0);
    chk("R1 oe idle", {31'd0, miso_oe_o}, 0);
    tx_data_i = 8'hA5; ss_ni = 1'b0; cyc(4);
    chk("R3 msb early", {31'd0, miso_o}, 1);
    chk("R1 oe selected", {31'd0, miso_oe_o}, 1);
    exp_q.push_back(8'h3C);
    #(HALF); run_bits(8'h3C, 8, 8'hA5, got);
    chk("R4 miso byte", {24'd0, got}, 32'hA5);
    sel(1'b1);
    xfer("R4 second byte", 8'h81, 8'h7E);

    // R2 polarity 1, phase 0
    set_mode(1'b1, 1'b0);
    xfer("R2 cpol1 cpha0", 8'hC3, 8'h5A);
    // R5 polarity 1, phase 1
    set_mode(1'b1, 1'b1);
    xfer("R5 cpol1 cpha1", 8'h96, 8'h0F);
    // R5 polarity 0, phase 1, two bytes one select
    set_mode(1'b0, 1'b1);
    tx_data_i = 8'hE1; exp_q.push_back(8'h12); exp_q.push_back(8'hF0);
    sel(1'b0);
    run_bits(8'h12, 8, 8'h4D, got);
    chk("R5 burst byte0", {24'd0, got}, 32'hE1);
    run_bits(8'hF0, 8, 8'h4D, got);
    chk("R5 burst byte1", {24'd0, got}, 32'h4D);
    sel(1'b1);

    // R8 abort mid-byte (phase 0)
    set_mode(1'b0, 1'b0);
    tx_data_i = 8'h55; sel(1'b0);
    run_bits(8'hFF, 4, 8'h55, got);
    sel(1'b1);
    chk("R8 no pending", exp_q.size(), 0);
    xfer("R8 after abort", 8'h6B, 8'h99);

    // R7 ninth edge
    tx_data_i = 8'h33; exp_q.push_back(8'hD2);
    sel(1'b0);
    run_bits(8'hD2, 8, 8'h33, got);
    chk("R7 no err at 8", {31'd0, frame_err_o}, 0);
    run_bits(8'hFF, 1, 8'h33, got);
    chk("R7 err set", {31'd0, frame_err_o}, 1);
    sel(1'b1);
    chk("R7 err held", {31'd0, frame_err_o}, 1);
    ss_ni = 1'b0; cyc(6);
    chk("R7 err cleared", {31'd0, frame_err_o}, 0);
    ss_ni = 1'b1; cyc(6);
    chk("R1 oe released", {31'd0, miso_oe_o}, 0);

    // R9 write while enabled ignored
    cpol_i = 1'b1; cpha_i = 1'b1; cfg_we_i = 1'b1; cyc(1); cfg_we_i = 1'b0;
    xfer("R9 mode kept", 8'h4E, 8'hB7);

    cyc(20);
    chk("R6 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule